// File: doc/BRIEF.md
# Interpolating Rising-Edge Trigger

This block watches a stream of signed converter samples and fires when the signal rises through a programmable level. It also reports how far between the two samples around the crossing the level was reached. The input bus carries several converter lanes side by side. Only one lane, chosen at build time, feeds the trigger, so the trigger sees every raw sample of that lane at the full converter rate. Any decimation of stored data happens downstream and has no effect here.

A crossing is the sample pair (previous below the level, current at or above it). When it sees one, the block latches that current sample's position in the stream. It then runs a small shift-and-subtract divider that places the crossing by straight-line interpolation, in fiftieths of a sample period. When the divider finishes, the block gives a one-cycle strobe together with the sample index and the fraction. While the divider is running, and for a programmable number of further samples, new crossings are ignored. The block then re-arms.

Top module: `crossing_trigger`

## Requirements
- R1: A trigger is accepted when, on a valid sample of the trigger lane, the previous valid sample is strictly below `level` and the current one is at or above it (signed two's complement compare). `trigStrobe` is high for exactly one cycle, 7 clock cycles after the clock edge that takes in the current sample.
- R2: `trigFrac` equals floor(50 * (level - prev) / (cur - prev)), limited to 49 when the quotient reaches 50.
- R3: Whenever `trigStrobe` is high, `trigFrac` lies in 0..49.
- R4: `trigIndex` is the zero-based count, since reset, of valid samples that came before the crossing's current sample.
- R5: An excursion above the level that lasts a single sample still produces a trigger.
- R6: Only lane TRIG_LANE (default 0, bits [7:0] of `laneData`) is examined. A crossing on any other lane produces no trigger.
- R7: A crossing taken in while a result is being computed is ignored. A crossing taken in during the cycle in which `trigStrobe` is high is accepted, and the result being delivered is not disturbed.
- R8: After an accepted crossing, the next `holdoff` valid samples cannot trigger. The previous-sample tracking continues through them.
- R9: A synchronous reset clears the stored previous sample and the output strobe, so the first sample after reset never triggers.
- R10: Cycles with `sampleValid` low change neither the previous sample nor the sample index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | All lanes carry a new sample this cycle |
| laneData | input | LANES*SAMPLE_W (16) | Packed lane samples, lane 0 in the low bits |
| level | input | SAMPLE_W (8) | Signed trigger level |
| holdoff | input | HOLD_W (8) | Valid samples to skip after a trigger |
| trigStrobe | output | 1 | One-cycle trigger result strobe |
| trigIndex | output | IDX_W (16) | Index of the sample after the crossing |
| trigFrac | output | 6 | Crossing offset after the previous sample, in 1/50 sample |

## Verification
Two events can fall in the same cycle: delivering a finished result on the strobe, and accepting the next crossing, which reloads the divider. The bench provokes this with a continuous stream and no holdoff. A second crossing is placed so that its current sample is taken in at the first edge after the divider goes idle, which is exactly the cycle in which the first strobe is high. The strobe is confirmed at that moment. Both results must then come out with their own index and fraction, and a crossing placed while the divider was still busy must produce nothing.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // fraction resolution: one sample period split into FRAC_STEPS parts
  localparam int FRAC_STEPS = 50;
  localparam int FRAC_MAX   = FRAC_STEPS - 1;
  localparam int FRAC_W     = 6;

  // commands from control to datapath
  typedef struct packed {
    logic start;   // load divider and capture index
    logic step;    // one restoring-division step
    logic finish;  // last step, publish result
  } ctrlCmd_t;
endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int LANES     = 2,
  parameter int TRIG_LANE = 0,
  parameter int IDX_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sampleValid,
  input  logic [LANES*SAMPLE_W-1:0]   laneData,
  input  logic signed [SAMPLE_W-1:0]  level,
  input  ctrlCmd_t                    cmd,
  output logic                        crossing,
  output logic                        trigStrobe,
  output logic [IDX_W-1:0]            trigIndex,
  output logic [FRAC_W-1:0]           trigFrac
);
  localparam int REM_W = SAMPLE_W + FRAC_W;

  logic signed [SAMPLE_W-1:0] curSample;
  logic signed [SAMPLE_W-1:0] prevSample;
  logic                       prevValid;
  logic [IDX_W-1:0]           sampleCount;
  logic [IDX_W-1:0]           pendIdx;

  logic [SAMPLE_W:0]          numDiff;
  logic [SAMPLE_W:0]          denDiff;
  logic [REM_W-1:0]           numScaled;
  logic [REM_W-1:0]           denShifted;

  logic [REM_W-1:0]           remReg;
  logic [REM_W-1:0]           divReg;
  logic [FRAC_W-1:0]          quotReg;
  logic                       fits;
  logic [REM_W-1:0]           stepRem;
  logic [FRAC_W-1:0]          stepQuot;
  logic [FRAC_W-1:0]          fracClamped;

  assign curSample = $signed(laneData[TRIG_LANE*SAMPLE_W +: SAMPLE_W]);

  // rising crossing on the trigger lane only
  assign crossing = sampleValid && prevValid &&
                    (prevSample < level) && (curSample >= level);

  // both differences are positive whenever a crossing is accepted
  assign numDiff = {level[SAMPLE_W-1], level} - {prevSample[SAMPLE_W-1], prevSample};
  assign denDiff = {curSample[SAMPLE_W-1], curSample} - {prevSample[SAMPLE_W-1], prevSample};
  assign numScaled  = REM_W'(numDiff[SAMPLE_W-1:0]) * REM_W'(FRAC_STEPS);
  assign denShifted = REM_W'(denDiff[SAMPLE_W-1:0]) << (FRAC_W - 1);

  // one restoring-division step
  assign fits     = remReg >= divReg;
  assign stepRem  = fits ? (remReg - divReg) : remReg;
  assign stepQuot = {quotReg[FRAC_W-2:0], fits};
  assign fracClamped = (stepQuot > FRAC_W'(FRAC_MAX)) ? FRAC_W'(FRAC_MAX) : stepQuot;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevValid   <= 1'b0;
      prevSample  <= '0;
      sampleCount <= '0;
    end else if (sampleValid) begin
      prevValid   <= 1'b1;
      prevSample  <= curSample;
      sampleCount <= sampleCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg  <= '0;
      divReg  <= '0;
      quotReg <= '0;
      pendIdx <= '0;
    end else if (cmd.start) begin
      remReg  <= numScaled;
      divReg  <= denShifted;
      quotReg <= '0;
      pendIdx <= sampleCount;
    end else if (cmd.step) begin
      remReg  <= stepRem;
      divReg  <= divReg >> 1;
      quotReg <= stepQuot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigStrobe <= 1'b0;
      trigIndex  <= '0;
      trigFrac   <= '0;
    end else begin
      trigStrobe <= cmd.finish;
      if (cmd.finish) begin
        trigIndex <= pendIdx;
        trigFrac  <= fracClamped;
      end
    end
  end
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic              crossing,
  input  logic [HOLD_W-1:0] holdoff,
  output ctrlCmd_t          cmd
);
  localparam int CNT_W = $clog2(FRAC_W);

  logic              busy;
  logic [CNT_W-1:0]  bitCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              armed;

  assign armed      = !busy && (holdCnt == '0);
  assign cmd.start  = crossing && armed;
  assign cmd.step   = busy;
  assign cmd.finish = busy && (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bitCnt  <= '0;
      holdCnt <= '0;
    end else if (cmd.start) begin
      busy    <= 1'b1;
      bitCnt  <= CNT_W'(FRAC_W - 1);
      holdCnt <= holdoff;
    end else begin
      if (busy) begin
        if (bitCnt == '0) busy <= 1'b0;
        else              bitCnt <= bitCnt - 1'b1;
      end
      if (sampleValid && holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end
endmodule

// File: rtl/crossing_trigger.sv
module crossing_trigger
  import trig_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int LANES     = 2,
  parameter int TRIG_LANE = 0,
  parameter int IDX_W     = 16,
  parameter int HOLD_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic [LANES*SAMPLE_W-1:0]  laneData,
  input  logic [SAMPLE_W-1:0]        level,
  input  logic [HOLD_W-1:0]          holdoff,
  output logic                       trigStrobe,
  output logic [IDX_W-1:0]           trigIndex,
  output logic [FRAC_W-1:0]          trigFrac
);
  ctrlCmd_t cmd;
  logic     crossing;

  trig_datapath #(
    .SAMPLE_W(SAMPLE_W), .LANES(LANES), .TRIG_LANE(TRIG_LANE), .IDX_W(IDX_W)
  ) i_datapath (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .laneData(laneData),
    .level($signed(level)), .cmd(cmd), .crossing(crossing),
    .trigStrobe(trigStrobe), .trigIndex(trigIndex), .trigFrac(trigFrac)
  );

  trig_control #(.HOLD_W(HOLD_W)) i_control (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .crossing(crossing),
    .holdoff(holdoff), .cmd(cmd)
  );
endmodule

// File: rtl/trig_checker.sv
module trig_checker
  import trig_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sampleValid,
  input logic              trigStrobe,
  input logic [FRAC_W-1:0] trigFrac
);
  AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (rst)
    trigStrobe |-> (trigFrac <= FRAC_W'(FRAC_MAX))); // R3

  AST_STROBE_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    trigStrobe |-> $past(sampleValid, 7)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trigStrobe |=> !trigStrobe); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !trigStrobe); // R9
endmodule

bind crossing_trigger trig_checker i_checker (
  .clk(clk), .rst(rst), .sampleValid(sampleValid),
  .trigStrobe(trigStrobe), .trigFrac(trigFrac)
);

// File: tb/test_crossing_trigger.sv
module test_crossing_trigger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleValid = 1'b0;
  logic [15:0] laneData = '0;
  logic [7:0]  level = '0;
  logic [7:0]  holdoff = '0;
  logic        trigStrobe;
  logic [15:0] trigIndex;
  logic [5:0]  trigFrac;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crossing_trigger i_crossing_trigger (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .laneData(laneData),
    .level(level), .holdoff(holdoff), .trigStrobe(trigStrobe),
    .trigIndex(trigIndex), .trigFrac(trigFrac)
  );

  // strobe recorder, sampled away from the active edge
  int monCount = 0;
  int monIdx[0:31];
  int monFrac[0:31];
  always @(negedge clk) begin
    if (trigStrobe) begin
      if (monCount < 32) begin
        monIdx[monCount]  = int'(trigIndex);
        monFrac[monCount] = int'(trigFrac);
      end
      monCount = monCount + 1;
    end
  end

  // lvl, prev, cur, expect trigger, expected fraction
  typedef struct packed { int lvl; int p; int c; int hit; int frac; } vec_t;
  localparam vec_t VECS[11] = '{
    '{0,    -10,  10,  1, 25},
    '{0,    -1,   0,   1, 49},
    '{0,    0,    50,  0, 0},
    '{10,   -128, 127, 1, 27},
    '{126,  125,  127, 1, 25},
    '{-100, -128, 127, 1, 5},
    '{20,   0,    19,  0, 0},
    '{0,    -1,   127, 1, 0},
    '{5,    -5,   20,  1, 20},
    '{-128, -128, 127, 0, 0},
    '{127,  126,  127, 1, 49}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int s0, input int s1);
    laneData    = {8'(s1), 8'(s0)};
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int base;
    @(negedge clk);
    doReset();
    chk("R9", "strobe after reset", int'(trigStrobe), 0);

    // table of crossing pairs, each from a fresh reset
    for (int i = 0; i < 11; i++) begin
      doReset();
      level = 8'(VECS[i].lvl);
      base = monCount;
      drive(VECS[i].p, 0);
      drive(VECS[i].c, 0);
      drive(VECS[i].p, 0);          // excursion of a single sample (R5)
      repeat (12) @(negedge clk);
      chk("R1", $sformatf("vec%0d trigger count", i), monCount - base, VECS[i].hit);
      if (VECS[i].hit != 0 && monCount > base) begin
        chk("R2", $sformatf("vec%0d fraction", i), monFrac[base], VECS[i].frac);
        chk("R4", $sformatf("vec%0d index", i), monIdx[base], 1);
      end
    end

    // exact latency
    doReset();
    level = 8'd0;
    drive(-10, 0);
    drive(10, 0);
    repeat (5) @(negedge clk);
    chk("R1", "strobe low before latency", int'(trigStrobe), 0);
    @(negedge clk);
    chk("R1", "strobe at latency", int'(trigStrobe), 1);
    @(negedge clk);
    chk("R1", "strobe one cycle wide", int'(trigStrobe), 0);

    // reset clears previous sample; invalid cycles do not count
    doReset();
    drive(-50, 0);
    doReset();
    base = monCount;
    drive(50, 0);
    repeat (10) @(negedge clk);
    chk("R9", "first sample after reset", monCount - base, 0);
    drive(-50, 0);
    @(negedge clk);
    drive(50, 0);
    repeat (10) @(negedge clk);
    chk("R10", "trigger after gap", monCount - base, 1);
    chk("R10", "index skips invalid cycles", monIdx[base], 2);
    chk("R2", "fraction after gap", monFrac[base], 25);

    // other lane ignored
    doReset();
    base = monCount;
    drive(-50, -50);
    drive(-40, 50);
    repeat (10) @(negedge clk);
    chk("R6", "crossing on other lane", monCount - base, 0);
    drive(-50, 50);
    drive(50, -50);
    repeat (10) @(negedge clk);
    chk("R6", "crossing on trigger lane", monCount - base, 1);
    chk("R4", "lane test index", monIdx[base], 3);

    // holdoff of three samples
    doReset();
    holdoff = 8'd3;
    base = monCount;
    drive(-10, 0);
    drive(10, 0);
    repeat (10) @(negedge clk);
    drive(-10, 0);
    drive(10, 0);                  // blocked by holdoff
    drive(-10, 0);
    drive(10, 0);                  // re-armed
    repeat (10) @(negedge clk);
    chk("R8", "holdoff trigger count", monCount - base, 2);
    chk("R8", "index after holdoff", monIdx[base+1], 5);
    holdoff = 8'd0;

    // busy suppression and same-cycle delivery plus acceptance
    doReset();
    base = monCount;
    drive(-10, 0);                 // 0
    drive(10, 0);                  // 1 accepted
    drive(-20, 0);                 // 2
    drive(20, 0);                  // 3 ignored, busy
    drive(-20, 0);                 // 4
    drive(-20, 0);                 // 5
    drive(-20, 0);                 // 6
    drive(-20, 0);                 // 7
    chk("R7", "strobe while next crossing arrives", int'(trigStrobe), 1);
    drive(40, 0);                  // 8 accepted in strobe cycle
    repeat (12) @(negedge clk);
    chk("R7", "busy trigger count", monCount - base, 2);
    chk("R7", "first index", monIdx[base], 1);
    chk("R7", "first fraction", monFrac[base], 25);
    chk("R7", "second index", monIdx[base+1], 8);
    chk("R2", "second fraction", monFrac[base+1], 16);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule